// File: doc/BRIEF.md
# Serial Channel DMA Ready and Receive Interrupt Control

This block sits beside one channel of a serial communications controller. It holds the channel's one-byte transmit and receive buffers. It drives an active-low ready line that asks a DMA master to move the next byte. It also decides which received characters raise an interrupt. A single configuration write sets everything at once: whether the ready line is used at all, whether it follows the transmit or the receive buffer, and which receive-interrupt mode applies.

When the ready function is enabled and points at the transmit side, the line is low for as long as the transmit buffer is empty, so the DMA master refills it. When it points at the receive side, the line is low while a received byte waits, so the DMA master collects it. The line goes high in the same clock edge at which the DMA master writes or reads the byte.

Receive interrupts cover every received character. A vector-modify flag reports that a special condition came with the character: overrun, framing error or parity error. One mode leaves parity errors out of that flag. The interrupt and the flag stay set until the received byte is read.

Top module: `serial_dma_ready`

## Requirements
- R1: A synchronous reset clears all configuration fields and empties both buffers. It also sets `rdy_n` to 1 and `irq` to 0, and clears `irq_special` and both buffer data registers to 0.
- R2: Write bit 7 of `cfg_wdata` is the ready enable and write bit 6 is the ready function. While either stored bit is 0, `rdy_n` is 1, whatever the buffer states.
- R3: With bits 7 and 6 set and bit 5 (source select) at 0, `rdy_n` is 0 exactly while the transmit buffer is empty. A configuration write takes effect on `rdy_n` at the same edge that stores it.
- R4: `tx_wr` fills the transmit buffer at the next edge, and `rdy_n` rises at that edge in transmit mode. `tx_take` without `tx_wr` empties the buffer. When both are asserted together, the buffer stays full.
- R5: With bits 7, 6 and 5 set, `rdy_n` is 0 exactly while the receive buffer holds a byte. `rx_load` fills it at the next edge.
- R6: `rx_rd` without `rx_load` empties the receive buffer at the next edge, and `rdy_n` rises at that edge in receive mode. When both are asserted together, the buffer stays full with the new byte.
- R7: The receive-interrupt mode is write bits 4:3. Codes 0 and 1 raise no interrupt and no special flag on any character.
- R8: In mode code 2, every `rx_load` sets `irq` at the next edge. `irq_special` is also set when any of `rx_par_err`, `rx_ovr_err` or `rx_frm_err` came with the character.
- R9: In mode code 3, every `rx_load` sets `irq`. Only overrun or framing errors set `irq_special`, so a character with a parity error alone leaves `irq_special` at 0.
- R10: `irq` and `irq_special` stay set until `rx_rd`, which clears them at the next edge. A qualifying `rx_load` in the same cycle as `rx_rd` sets them again from the new character alone. Interrupt qualification uses the mode stored before that cycle's write.
- R11: `tx_data` shows the byte of the most recent `tx_wr`, and `rx_rdata` shows the byte of the most recent `rx_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Write bits 7:3 (enable, function, source select, interrupt mode) |
| tx_wr | input | 1 | DMA master writes a byte into the transmit buffer |
| tx_wdata | input | 8 | Byte written by the DMA master |
| tx_take | input | 1 | Serializer takes the transmit byte |
| tx_data | output | 8 | Transmit buffer contents |
| tx_full | output | 1 | Transmit buffer holds a byte |
| rx_load | input | 1 | Received character valid strobe |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error with this character |
| rx_ovr_err | input | 1 | Receive overrun with this character |
| rx_frm_err | input | 1 | Framing error with this character |
| rx_rd | input | 1 | DMA master reads the received byte |
| rx_rdata | output | 8 | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds a byte |
| rdy_n | output | 1 | Active-low DMA request |
| irq | output | 1 | Receive interrupt request |
| irq_special | output | 1 | Vector-modify flag for a special receive condition |

## Verification
The hardest case to reach is a parity-only error in mode code 3 that lands in the same cycle as a read of an earlier, framing-flagged byte. Here `irq` must stay high while `irq_special` must drop. Random stimulus almost never lines up a fresh mode write, a pending special flag, a read and a parity-only character, so a directed sequence builds this case step by step. The random phase then mixes configuration writes with simultaneous write/take and load/read pulses. This covers the edges where the ready source and the buffer state change together.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [1:0] {
    RXI_OFF       = 2'd0,
    RXI_RSVD      = 2'd1,
    RXI_ALL_PAR   = 2'd2,
    RXI_ALL_NOPAR = 2'd3
  } rxi_mode_e;

  typedef struct packed {
    logic      rdy_en;
    logic      rdy_fn;
    logic      rdy_rx;
    rxi_mode_e mode;
  } sdr_cfg_t;

  localparam sdr_cfg_t CFG_RESET = '{rdy_en: 1'b0, rdy_fn: 1'b0, rdy_rx: 1'b0, mode: RXI_OFF};

  // Receive interrupts are qualified only by the upper mode code bit.
  function automatic logic mode_irq_on(rxi_mode_e m);
    return m[1];
  endfunction

  function automatic logic err_is_special(rxi_mode_e m, logic par, logic ovr, logic frm);
    return ovr | frm | (par & (m == RXI_ALL_PAR));
  endfunction

endpackage

// File: rtl/sdr_cfg_reg.sv
module sdr_cfg_reg
  import sdr_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int EN_BIT   = 7,
  parameter int FN_BIT   = 6,
  parameter int SEL_BIT  = 5,
  parameter int MODE_LSB = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [CFG_W-1:MODE_LSB]   wdata,
  output sdr_cfg_t                  cfg_q,
  output sdr_cfg_t                  cfg_nxt
);
  localparam int MODE_W = $bits(rxi_mode_e);

  sdr_cfg_t wr_cfg;

  always_comb begin
    wr_cfg.rdy_en = wdata[EN_BIT];
    wr_cfg.rdy_fn = wdata[FN_BIT];
    wr_cfg.rdy_rx = wdata[SEL_BIT];
    wr_cfg.mode   = rxi_mode_e'(wdata[MODE_LSB +: MODE_W]);
    cfg_nxt       = we ? wr_cfg : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else     cfg_q <= cfg_nxt;
  end

endmodule

// File: rtl/sdr_byte_buf.sv
module sdr_byte_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put,
  input  logic [DATA_W-1:0] put_data,
  input  logic              take,
  output logic              full_q,
  output logic              full_nxt,
  output logic [DATA_W-1:0] data_q
);
  // A put in the same cycle as a take wins: the slot holds the new byte.
  always_comb full_nxt = put | (full_q & ~take);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_nxt;
      if (put) data_q <= put_data;
    end
  end

endmodule

// File: rtl/sdr_ready_gen.sv
module sdr_ready_gen
  import sdr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sdr_cfg_t cfg_nxt,
  input  logic     tx_full_nxt,
  input  logic     rx_full_nxt,
  output logic     rdy_n
);
  logic req_nxt;

  // Computed from next state so the pin moves at the same edge as the buffer.
  always_comb begin
    if (!(cfg_nxt.rdy_en && cfg_nxt.rdy_fn)) req_nxt = 1'b0;
    else if (cfg_nxt.rdy_rx)                 req_nxt = rx_full_nxt;
    else                                     req_nxt = ~tx_full_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) rdy_n <= 1'b1;
    else     rdy_n <= ~req_nxt;
  end

endmodule

// File: rtl/sdr_rx_irq.sv
module sdr_rx_irq
  import sdr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rxi_mode_e mode,
  input  logic      rx_load,
  input  logic      par_err,
  input  logic      ovr_err,
  input  logic      frm_err,
  input  logic      rx_rd,
  output logic      irq,
  output logic      irq_special
);
  logic hit, spec;

  always_comb begin
    hit  = rx_load & mode_irq_on(mode);
    spec = hit & err_is_special(mode, par_err, ovr_err, frm_err);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq         <= 1'b0;
      irq_special <= 1'b0;
    end else begin
      irq         <= (irq & ~rx_rd) | hit;
      irq_special <= (irq_special & ~rx_rd) | spec;
    end
  end

endmodule

// File: rtl/serial_dma_ready.sv
module serial_dma_ready
  import sdr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CFG_W    = 8,
  parameter int EN_BIT   = 7,
  parameter int FN_BIT   = 6,
  parameter int SEL_BIT  = 5,
  parameter int MODE_LSB = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:MODE_LSB] cfg_wdata,
  input  logic                    tx_wr,
  input  logic [DATA_W-1:0]       tx_wdata,
  input  logic                    tx_take,
  output logic [DATA_W-1:0]       tx_data,
  output logic                    tx_full,
  input  logic                    rx_load,
  input  logic [DATA_W-1:0]       rx_data,
  input  logic                    rx_par_err,
  input  logic                    rx_ovr_err,
  input  logic                    rx_frm_err,
  input  logic                    rx_rd,
  output logic [DATA_W-1:0]       rx_rdata,
  output logic                    rx_full,
  output logic                    rdy_n,
  output logic                    irq,
  output logic                    irq_special
);
  localparam int NUM_BUF = 2;
  localparam int BUF_TX  = 0;
  localparam int BUF_RX  = 1;

  sdr_cfg_t cfg_q, cfg_nxt;

  logic              buf_put  [NUM_BUF];
  logic              buf_take [NUM_BUF];
  logic [DATA_W-1:0] buf_din  [NUM_BUF];
  logic [DATA_W-1:0] buf_dout [NUM_BUF];
  logic              buf_full [NUM_BUF];
  logic              buf_fnxt [NUM_BUF];

  sdr_cfg_reg #(
    .CFG_W(CFG_W), .EN_BIT(EN_BIT), .FN_BIT(FN_BIT),
    .SEL_BIT(SEL_BIT), .MODE_LSB(MODE_LSB)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .cfg_q(cfg_q), .cfg_nxt(cfg_nxt)
  );

  always_comb begin
    buf_put[BUF_TX]  = tx_wr;
    buf_take[BUF_TX] = tx_take;
    buf_din[BUF_TX]  = tx_wdata;
    buf_put[BUF_RX]  = rx_load;
    buf_take[BUF_RX] = rx_rd;
    buf_din[BUF_RX]  = rx_data;
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    sdr_byte_buf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst(rst),
      .put(buf_put[g]), .put_data(buf_din[g]), .take(buf_take[g]),
      .full_q(buf_full[g]), .full_nxt(buf_fnxt[g]), .data_q(buf_dout[g])
    );
  end

  always_comb begin
    tx_data  = buf_dout[BUF_TX];
    tx_full  = buf_full[BUF_TX];
    rx_rdata = buf_dout[BUF_RX];
    rx_full  = buf_full[BUF_RX];
  end

  sdr_ready_gen u_rdy (
    .clk(clk), .rst(rst), .cfg_nxt(cfg_nxt),
    .tx_full_nxt(buf_fnxt[BUF_TX]), .rx_full_nxt(buf_fnxt[BUF_RX]),
    .rdy_n(rdy_n)
  );

  sdr_rx_irq u_irq (
    .clk(clk), .rst(rst), .mode(cfg_q.mode), .rx_load(rx_load),
    .par_err(rx_par_err), .ovr_err(rx_ovr_err), .frm_err(rx_frm_err),
    .rx_rd(rx_rd), .irq(irq), .irq_special(irq_special)
  );

endmodule

// File: rtl/sdr_checker.sv
module sdr_checker
  import sdr_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input sdr_cfg_t cfg_q,
  input logic     tx_wr,
  input logic     tx_full,
  input logic     rx_load,
  input logic     rx_rd,
  input logic     rx_full,
  input logic     rx_par_err,
  input logic     rx_ovr_err,
  input logic     rx_frm_err,
  input logic     rdy_n,
  input logic     irq,
  input logic     irq_special
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (rdy_n && !irq && !irq_special && !tx_full && !rx_full));

  assert_rdy_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_q.rdy_en && cfg_q.rdy_fn) |-> rdy_n);

  assert_txwr_fills_R4: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> tx_full);

  assert_rxload_fills_R5: assert property (@(posedge clk) disable iff (rst)
    rx_load |=> rx_full);

  assert_rxrd_empties_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !rx_load) |=> !rx_full);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(rx_load && cfg_q.mode[1]));

  assert_parity_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_load && cfg_q.mode == RXI_ALL_NOPAR && !rx_ovr_err && !rx_frm_err &&
     (rx_rd || !irq_special)) |=> !irq_special);

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && !rx_rd) |=> irq);

  assert_special_needs_irq_R8: assert property (@(posedge clk) disable iff (rst)
    irq_special |-> irq);

  assert_special_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_special) |-> $past(rx_load && (rx_par_err || rx_ovr_err || rx_frm_err)));

endmodule

bind serial_dma_ready sdr_checker u_chk (
  .clk(clk), .rst(rst), .cfg_q(cfg_q),
  .tx_wr(tx_wr), .tx_full(tx_full),
  .rx_load(rx_load), .rx_rd(rx_rd), .rx_full(rx_full),
  .rx_par_err(rx_par_err), .rx_ovr_err(rx_ovr_err), .rx_frm_err(rx_frm_err),
  .rdy_n(rdy_n), .irq(irq), .irq_special(irq_special)
);

// File: tb/test_serial_dma_ready.sv
module test_serial_dma_ready;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:3] cfg_wdata = '0;
  logic       tx_wr = 1'b0, tx_take = 1'b0;
  logic [7:0] tx_wdata = '0, rx_data = '0;
  logic       rx_load = 1'b0, rx_rd = 1'b0;
  logic       rx_par_err = 1'b0, rx_ovr_err = 1'b0, rx_frm_err = 1'b0;
  logic [7:0] tx_data, rx_rdata;
  logic       tx_full, rx_full, rdy_n, irq, irq_special;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state
  logic [7:3] m_cfg;
  logic       m_txf, m_rxf, m_irq, m_spc, m_rdy_n;
  logic [7:0] m_txd, m_rxd;

  always #5 clk = ~clk;

  serial_dma_ready i_serial_dma_ready (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_take(tx_take),
    .tx_data(tx_data), .tx_full(tx_full),
    .rx_load(rx_load), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_ovr_err(rx_ovr_err), .rx_frm_err(rx_frm_err), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_full(rx_full), .rdy_n(rdy_n),
    .irq(irq), .irq_special(irq_special)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_ready_n(input logic [7:3] c, input logic txf, input logic rxf);
    if (!(c[7] && c[6])) return 1'b1;
    return c[5] ? !rxf : txf;
  endfunction

  function automatic logic exp_special(input logic [1:0] mode, input logic par,
                                       input logic ovr, input logic frm);
    return ovr | frm | (par & (mode == 2'd2));
  endfunction

  task automatic model_reset();
    m_cfg = '0; m_txf = 0; m_rxf = 0; m_irq = 0; m_spc = 0;
    m_rdy_n = 1; m_txd = '0; m_rxd = '0;
  endtask

  task automatic idle_inputs();
    cfg_we = 0; tx_wr = 0; tx_take = 0; rx_load = 0; rx_rd = 0;
    rx_par_err = 0; rx_ovr_err = 0; rx_frm_err = 0;
  endtask

  // Advance one cycle: update model from current inputs, clock, compare at negedge.
  task automatic tick();
    logic [1:0] mode;
    logic hit;
    string rtag;
    mode = m_cfg[4:3];
    hit  = rx_load && mode[1];
    m_irq = (m_irq && !rx_rd) || hit;
    m_spc = (m_spc && !rx_rd) || (hit && exp_special(mode, rx_par_err, rx_ovr_err, rx_frm_err));
    if (cfg_we) m_cfg = cfg_wdata;
    m_txf = tx_wr || (m_txf && !tx_take);
    if (tx_wr) m_txd = tx_wdata;
    m_rxf = rx_load || (m_rxf && !rx_rd);
    if (rx_load) m_rxd = rx_data;
    m_rdy_n = exp_ready_n(m_cfg, m_txf, m_rxf);
    @(posedge clk);
    @(negedge clk);
    rtag = !(m_cfg[7] && m_cfg[6]) ? "R2 rdy_n" : (m_cfg[5] ? "R5 rdy_n" : "R3 rdy_n");
    chk(rtag, rdy_n, m_rdy_n);
    chk("R4 tx_full", tx_full, m_txf);
    chk("R6 rx_full", rx_full, m_rxf);
    chk("R8 irq", irq, m_irq);
    chk("R9 irq_special", irq_special, m_spc);
    chk("R11 tx_data", tx_data, m_txd);
    chk("R11 rx_rdata", rx_rdata, m_rxd);
  endtask

  task automatic write_cfg(input logic [7:3] v);
    idle_inputs(); cfg_we = 1; cfg_wdata = v; tick(); idle_inputs();
  endtask

  task automatic load_char(input logic [7:0] d, input logic p, input logic o, input logic f);
    idle_inputs(); rx_load = 1; rx_data = d;
    rx_par_err = p; rx_ovr_err = o; rx_frm_err = f; tick(); idle_inputs();
  endtask

  task automatic read_char();
    idle_inputs(); rx_rd = 1; tick(); idle_inputs();
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4099));
    model_reset();
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 rdy_n", rdy_n, 1'b1);
    chk("R1 irq", irq, 1'b0);
    chk("R1 irq_special", irq_special, 1'b0);
    chk("R1 tx_full", tx_full, 1'b0);
    chk("R1 rx_full", rx_full, 1'b0);

    // R2: function only, enable clear -> idle high with empty tx
    write_cfg(5'b01000);
    chk("R2 rdy_n idle", rdy_n, 1'b1);

    // R3: transmit source, empty buffer -> low at the write edge
    write_cfg(5'b11000);
    chk("R3 rdy_n low on empty tx", rdy_n, 1'b0);
    // R4: write raises, take lowers, write+take keeps full
    idle_inputs(); tx_wr = 1; tx_wdata = 8'hA5; tick();
    chk("R4 rdy_n high after write", rdy_n, 1'b1);
    chk("R11 tx_data", tx_data, 8'hA5);
    idle_inputs(); tx_wr = 1; tx_take = 1; tx_wdata = 8'h3C; tick();
    chk("R4 full kept on write+take", tx_full, 1'b1);
    idle_inputs(); tx_take = 1; tick();
    chk("R4 rdy_n low after take", rdy_n, 1'b0);
    idle_inputs();

    // R5/R6: receive source
    write_cfg(5'b11100);
    chk("R5 rdy_n high on empty rx", rdy_n, 1'b1);
    load_char(8'h5A, 0, 0, 0);
    chk("R5 rdy_n low with rx byte", rdy_n, 1'b0);
    chk("R7 no irq in mode 0", irq, 1'b0);
    read_char();
    chk("R6 rdy_n high after read", rdy_n, 1'b1);

    // R7: mode code 1 with errors
    write_cfg(5'b11101);
    load_char(8'h11, 1, 1, 1);
    chk("R7 no irq in mode 1", irq, 1'b0);
    chk("R7 no special in mode 1", irq_special, 1'b0);
    read_char();

    // R8: mode code 2, parity error is special
    write_cfg(5'b11110);
    load_char(8'h22, 1, 0, 0);
    chk("R8 irq mode 2", irq, 1'b1);
    chk("R8 parity special mode 2", irq_special, 1'b1);
    load_char(8'h23, 0, 0, 0);
    chk("R10 irq held", irq, 1'b1);
    chk("R10 special held", irq_special, 1'b1);
    read_char();
    chk("R10 irq cleared by read", irq, 1'b0);

    // R9/R10: mode code 3, pending framing special, read + parity-only load
    write_cfg(5'b11111);
    load_char(8'h33, 0, 0, 1);
    chk("R9 framing special mode 3", irq_special, 1'b1);
    idle_inputs(); rx_rd = 1; rx_load = 1; rx_data = 8'h44; rx_par_err = 1; tick();
    chk("R9 parity alone not special", irq_special, 1'b0);
    chk("R10 irq re-set by same-cycle load", irq, 1'b1);
    chk("R6 full kept on load+read", rx_full, 1'b1);
    chk("R11 rx_rdata", rx_rdata, 8'h44);
    idle_inputs();
    // R10: mode change applies to the next character only
    idle_inputs(); rx_rd = 1; cfg_we = 1; cfg_wdata = 5'b11100; rx_load = 1;
    rx_data = 8'h55; tick();
    chk("R10 old mode qualifies same-cycle load", irq, 1'b1);
    idle_inputs();
    read_char();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      cfg_we     = ($urandom_range(0, 15) == 0);
      cfg_wdata  = 5'($urandom);
      tx_wr      = ($urandom_range(0, 3) == 0);
      tx_take    = ($urandom_range(0, 3) == 0);
      tx_wdata   = 8'($urandom);
      rx_load    = ($urandom_range(0, 3) == 0);
      rx_rd      = ($urandom_range(0, 3) == 0);
      rx_data    = 8'($urandom);
      rx_par_err = ($urandom_range(0, 3) == 0);
      rx_ovr_err = ($urandom_range(0, 5) == 0);
      rx_frm_err = ($urandom_range(0, 5) == 0);
      tick();
    end
    idle_inputs();

    // R1: reset mid-run
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    chk("R1 rdy_n after reset", rdy_n, 1'b1);
    chk("R1 rx_rdata after reset", rx_rdata, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule